// File: doc/BRIEF.md
# Integer Execute Unit with Signed-Overflow Trap

This block is the integer execute stage of a load-store RISC core. Each cycle it can take two 32-bit source operands, a 16-bit immediate, an immediate-select bit, a 5-bit constant shift amount and a 4-bit operation code. One clock edge later it returns a 32-bit result, a signed-overflow flag and a register write enable. The unit covers trapping and non-trapping add and subtract, the four bitwise operations including NOR, constant-amount and register-amount shifts, and signed and unsigned set-less-than. Multiply, divide, memory access and branch resolution are handled elsewhere in the core.

When the immediate select is high, the second operand is replaced by the immediate. The immediate is zero-extended for the bitwise operations and sign-extended for every other operation. A trapping add or subtract that overflows as two's complement raises the overflow flag and drops the write enable, so the destination register keeps its old value. The wrapped sum still appears on the result port.

Top module: `ialu_exec`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it rises, `vld_o`, `ovf_o` and `wr_en_o` are 0 and `res_o` is 0.
- R2: An operation presented with `vld_i`=1 at a rising edge appears on `res_o`/`ovf_o` with `vld_o`=1 right after that edge, so the latency is one cycle. `vld_o` is 0 after an edge where `vld_i` was 0. `wr_en_o` equals `vld_o` AND NOT `ovf_o`.
- R3: The trapping add (op 0) and trapping subtract (op 2) set `ovf_o` exactly when the two's-complement result does not fit in 32 bits. In that case `wr_en_o` is 0 and `res_o` still carries the wrapped value.
- R4: Unsigned add (op 1), unsigned subtract (op 3) and all ops 4 to 15 never set `ovf_o`. Their wrapped 32-bit add/sub result is written with `wr_en_o`=1.
- R5: With `imm_sel_i`=1, the second operand is `imm_i` zero-extended to 32 bits for ops 4 to 7 and sign-extended from bit 15 for all other ops.
- R6: Op 4 gives A AND B, op 5 gives A OR B, op 6 gives A XOR B and op 7 gives NOT (A OR B), all bitwise across 32 bits.
- R7: Ops 8, 9 and 10 shift `src_a_i` by `shamt_i`: left logical, right logical, and right arithmetic (sign-filling).
- R8: Ops 11, 12 and 13 shift `src_a_i` in the same three ways as R7 by the low 5 bits of the second operand. Bits 31:5 of that operand have no effect.
- R9: Op 14 returns 1 when A < B as signed two's complement and 0 otherwise. Op 15 returns 1 when A < B as unsigned numbers. Bits 31:1 of both results are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| vld_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code (0..15, see requirements) |
| src_a_i | input | 32 | First operand, also the value that is shifted |
| src_b_i | input | 32 | Second operand when no immediate is selected |
| imm_i | input | 16 | Immediate field |
| imm_sel_i | input | 1 | Use the extended immediate as the second operand |
| shamt_i | input | 5 | Constant shift amount for ops 8 to 10 |
| vld_o | output | 1 | Result valid |
| res_o | output | 32 | Result |
| ovf_o | output | 1 | Signed overflow on a trapping add or subtract |
| wr_en_o | output | 1 | Destination register write enable |

## Verification
The bound checker covers the following properties on every cycle: valid follows input valid by one edge, overflow always blocks the write enable, the non-trapping operations never flag overflow, NOR and register-amount left shift give the expected values, set-less-than results have clear upper bits, and an overflowing register add raises the flag. Several behaviours can only be shown by the bench's directed and randomized scenarios. These are immediate extension choosing zero or sign fill by operation, the boundary operands at the most positive and most negative values, arithmetic right shifts of negative numbers, and signed versus unsigned ordering of the same bit patterns.

// File: rtl/ialu_pkg.sv
package ialu_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,  OP_ADDU = 4'd1,  OP_SUB  = 4'd2,  OP_SUBU = 4'd3,
        OP_AND  = 4'd4,  OP_OR   = 4'd5,  OP_XOR  = 4'd6,  OP_NOR  = 4'd7,
        OP_SLL  = 4'd8,  OP_SRL  = 4'd9,  OP_SRA  = 4'd10, OP_SLLV = 4'd11,
        OP_SRLV = 4'd12, OP_SRAV = 4'd13, OP_SLT  = 4'd14, OP_SLTU = 4'd15
    } alu_op_e;

    function automatic logic is_bitwise(alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOR);
    endfunction
endpackage

// File: rtl/ialu_operand.sv
module ialu_operand #(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic [W-1:0]     reg_b_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             imm_sel_i,
    input  logic             zero_ext_i,
    output logic [W-1:0]     opnd_o
);
    localparam int PAD = W - IMM_W;

    logic fill;
    logic [W-1:0] ext;

    always_comb begin
        fill   = zero_ext_i ? 1'b0 : imm_i[IMM_W-1];
        ext    = {{PAD{fill}}, imm_i};
        opnd_o = imm_sel_i ? ext : reg_b_i;
    end
endmodule

// File: rtl/ialu_arith.sv
module ialu_arith #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o,
    output logic         lt_s_o,
    output logic         lt_u_o
);
    logic [W-1:0] bx;
    logic         cout;

    always_comb begin
        bx           = sub_i ? ~b_i : b_i;
        {cout, sum_o} = {1'b0, a_i} + {1'b0, bx} + {{W{1'b0}}, sub_i};
        ovf_o        = (a_i[W-1] == bx[W-1]) && (sum_o[W-1] != a_i[W-1]);
        lt_s_o       = sum_o[W-1] ^ ovf_o;
        lt_u_o       = ~cout;
    end
endmodule

// File: rtl/ialu_shifter.sv
module ialu_shifter #(
    parameter int W    = 32,
    parameter int SH_W = $clog2(W)
) (
    input  logic [W-1:0]    data_i,
    input  logic [SH_W-1:0] amt_i,
    input  logic            left_i,
    input  logic            arith_i,
    output logic [W-1:0]    data_o
);
    logic                  fill;
    logic [W-1:0]          din;
    logic [SH_W:0][W-1:0]  stg;

    assign fill   = arith_i & ~left_i & data_i[W-1];
    assign stg[0] = din;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign din[i]    = left_i ? data_i[W-1-i] : data_i[i];
        assign data_o[i] = left_i ? stg[SH_W][W-1-i] : stg[SH_W][i];
    end

    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        localparam int D = 1 << s;
        assign stg[s+1] = amt_i[s] ? {{D{fill}}, stg[s][W-1:D]} : stg[s];
    end
endmodule

// File: rtl/ialu_exec.sv
module ialu_exec
    import ialu_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 16,
    parameter int SH_W  = $clog2(W)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             vld_i,
    input  logic [3:0]       op_i,
    input  logic [W-1:0]     src_a_i,
    input  logic [W-1:0]     src_b_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             imm_sel_i,
    input  logic [SH_W-1:0]  shamt_i,
    output logic             vld_o,
    output logic [W-1:0]     res_o,
    output logic             ovf_o,
    output logic             wr_en_o
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
        logic         ovf;
    } stage_t;

    stage_t st_d, st_q;
    alu_op_e op;

    logic [W-1:0]    opnd_b;
    logic [W-1:0]    sum;
    logic            ar_ovf, lt_s, lt_u, do_sub;
    logic [W-1:0]    sh_out;
    logic [SH_W-1:0] sh_amt;
    logic            sh_left, sh_arith;

    assign op = alu_op_e'(op_i);

    ialu_operand #(.W(W), .IMM_W(IMM_W)) u_opnd (
        .reg_b_i   (src_b_i),
        .imm_i     (imm_i),
        .imm_sel_i (imm_sel_i),
        .zero_ext_i(is_bitwise(op)),
        .opnd_o    (opnd_b)
    );

    always_comb begin
        do_sub   = (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);
        sh_left  = (op == OP_SLL) || (op == OP_SLLV);
        sh_arith = (op == OP_SRA) || (op == OP_SRAV);
        sh_amt   = ((op == OP_SLLV) || (op == OP_SRLV) || (op == OP_SRAV))
                   ? opnd_b[SH_W-1:0] : shamt_i;
    end

    ialu_arith #(.W(W)) u_arith (
        .a_i   (src_a_i),
        .b_i   (opnd_b),
        .sub_i (do_sub),
        .sum_o (sum),
        .ovf_o (ar_ovf),
        .lt_s_o(lt_s),
        .lt_u_o(lt_u)
    );

    ialu_shifter #(.W(W), .SH_W(SH_W)) u_shift (
        .data_i (src_a_i),
        .amt_i  (sh_amt),
        .left_i (sh_left),
        .arith_i(sh_arith),
        .data_o (sh_out)
    );

    always_comb begin
        logic [W-1:0] r;
        unique case (op)
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: r = sum;
            OP_AND:  r = src_a_i & opnd_b;
            OP_OR:   r = src_a_i | opnd_b;
            OP_XOR:  r = src_a_i ^ opnd_b;
            OP_NOR:  r = ~(src_a_i | opnd_b);
            OP_SLT:  r = {{(W-1){1'b0}}, lt_s};
            OP_SLTU: r = {{(W-1){1'b0}}, lt_u};
            default: r = sh_out;
        endcase
        st_d     = st_q;
        st_d.vld = vld_i;
        st_d.ovf = vld_i && ar_ovf && ((op == OP_ADD) || (op == OP_SUB));
        if (vld_i) begin
            st_d.res = r;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o   = st_q.vld;
    assign res_o   = st_q.res;
    assign ovf_o   = st_q.ovf;
    assign wr_en_o = st_q.vld & ~st_q.ovf;
endmodule

// File: rtl/ialu_exec_chk.sv
module ialu_exec_chk #(
    parameter int W     = 32,
    parameter int IMM_W = 16,
    parameter int SH_W  = $clog2(W)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             vld_i,
    input logic [3:0]       op_i,
    input logic [W-1:0]     src_a_i,
    input logic [W-1:0]     src_b_i,
    input logic             imm_sel_i,
    input logic             vld_o,
    input logic [W-1:0]     res_o,
    input logic             ovf_o,
    input logic             wr_en_o
);
    logic [W-1:0] plain_sum;
    assign plain_sum = src_a_i + src_b_i;

    // R2
    vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_i |=> vld_o);

    // R2
    idle_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vld_i |=> !vld_o && !wr_en_o);

    // R3
    ovf_blocks_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |-> !wr_en_o);

    // R4
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_i && op_i != 4'd0 && op_i != 4'd2) |=> !ovf_o && wr_en_o);

    // R3
    add_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_i && op_i == 4'd0 && !imm_sel_i && src_a_i[W-1] == src_b_i[W-1]
         && plain_sum[W-1] != src_a_i[W-1]) |=> ovf_o);

    // R6
    nor_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_i && op_i == 4'd7 && !imm_sel_i) |=> res_o == ~($past(src_a_i) | $past(src_b_i)));

    // R8
    var_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_i && op_i == 4'd11 && !imm_sel_i) |=> res_o == ($past(src_a_i) << $past(src_b_i[SH_W-1:0])));

    // R9
    slt_narrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_i && op_i >= 4'd14) |=> res_o[W-1:1] == '0);
endmodule

bind ialu_exec ialu_exec_chk #(.W(W), .IMM_W(IMM_W), .SH_W(SH_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (vld_i),
    .op_i     (op_i),
    .src_a_i  (src_a_i),
    .src_b_i  (src_b_i),
    .imm_sel_i(imm_sel_i),
    .vld_o    (vld_o),
    .res_o    (res_o),
    .ovf_o    (ovf_o),
    .wr_en_o  (wr_en_o)
);

// File: tb/sim_ialu_exec.sv
module sim_ialu_exec;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] a_i = '0, b_i = '0;
    logic [15:0] imm_i = '0;
    logic        isel_i = 1'b0;
    logic [4:0]  sh_i = '0;
    logic        vld_o, ovf_o, wr_en_o;
    logic [31:0] res_o;

    typedef struct {
        int          cyc;
        logic [31:0] res;
        logic        ovf;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0, n_fail = 0, cyc = 0;
    bit   done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ialu_exec u0 (
        .clk_i(clk), .rst_ni(rst_n), .vld_i(vld_i), .op_i(op_i),
        .src_a_i(a_i), .src_b_i(b_i), .imm_i(imm_i), .imm_sel_i(isel_i),
        .shamt_i(sh_i), .vld_o(vld_o), .res_o(res_o), .ovf_o(ovf_o),
        .wr_en_o(wr_en_o)
    );

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(logic [3:0] op);
        if (op == 0 || op == 2) return "R3";
        if (op == 1 || op == 3) return "R4";
        if (op <= 7)  return "R6";
        if (op <= 10) return "R7";
        if (op <= 13) return "R8";
        return "R9";
    endfunction

    // expected model written from the requirements
    task automatic model(input logic [3:0] op, input logic [31:0] a, b,
                         input logic [15:0] imm, input logic isel, input logic [4:0] sh,
                         output logic [31:0] r, output logic ovf);
        logic [31:0] bx;
        logic [32:0] wide;
        bx  = !isel ? b : ((op >= 4 && op <= 7) ? {16'h0, imm} : {{16{imm[15]}}, imm});
        ovf = 1'b0;
        case (op)
            4'd0, 4'd1: r = a + bx;
            4'd2, 4'd3: r = a - bx;
            4'd4: r = a & bx;
            4'd5: r = a | bx;
            4'd6: r = a ^ bx;
            4'd7: r = ~(a | bx);
            4'd8: r = a << sh;
            4'd9: r = a >> sh;
            4'd10: r = $unsigned($signed(a) >>> sh);
            4'd11: r = a << bx[4:0];
            4'd12: r = a >> bx[4:0];
            4'd13: r = $unsigned($signed(a) >>> bx[4:0]);
            4'd14: r = ($signed(a) < $signed(bx)) ? 32'd1 : 32'd0;
            default: r = (a < bx) ? 32'd1 : 32'd0;
        endcase
        if (op == 4'd0) begin
            wide = {a[31], a} + {bx[31], bx};
            ovf  = wide[32] ^ wide[31];
        end else if (op == 4'd2) begin
            wide = {a[31], a} - {bx[31], bx};
            ovf  = wide[32] ^ wide[31];
        end
    endtask

    task automatic drive(logic [3:0] op, logic [31:0] a, b, logic [15:0] imm,
                         logic isel, logic [4:0] sh, string tag);
        exp_t e;
        @(negedge clk);
        vld_i = 1'b1; op_i = op; a_i = a; b_i = b; imm_i = imm; isel_i = isel; sh_i = sh;
        model(op, a, b, imm, isel, sh, e.res, e.ovf);
        e.cyc = cyc;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            vld_i = 1'b0;
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (q.size() > 0 && q[0].cyc < cyc) begin
                    exp_t e;
                    e = q.pop_front();
                    check(vld_o == 1'b1, "R2", "vld_o", {31'b0, vld_o}, 32'd1);
                    check(res_o == e.res, e.tag, "res_o", res_o, e.res);
                    check(ovf_o == e.ovf, e.ovf ? "R3" : "R4", "ovf_o", {31'b0, ovf_o}, {31'b0, e.ovf});
                    check(wr_en_o == !e.ovf, "R2", "wr_en_o", {31'b0, wr_en_o}, {31'b0, !e.ovf});
                end else begin
                    check(vld_o == 1'b0 && wr_en_o == 1'b0, "R2", "idle vld_o/wr_en_o",
                          {30'b0, vld_o, wr_en_o}, 32'd0);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(vld_o == 0 && ovf_o == 0 && wr_en_o == 0, "R1", "flags in reset",
              {29'b0, vld_o, ovf_o, wr_en_o}, 32'd0);
        check(res_o == 32'd0, "R1", "res_o in reset", res_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(vld_o == 0 && res_o == 0, "R1", "after reset", res_o, 32'd0);

        drive(4'd0, 32'h7fff_ffff, 32'd1, 16'h0, 0, 0, "R3");
        drive(4'd2, 32'h8000_0000, 32'd1, 16'h0, 0, 0, "R3");
        drive(4'd2, 32'h7fff_ffff, 32'hffff_ffff, 16'h0, 0, 0, "R3");
        drive(4'd0, 32'h8000_0000, 32'h8000_0000, 16'h0, 0, 0, "R3");
        drive(4'd0, 32'h7fff_ffff, 32'd0, 16'h0001, 1, 0, "R3");
        drive(4'd1, 32'h7fff_ffff, 32'd1, 16'h0, 0, 0, "R4");
        drive(4'd3, 32'h8000_0000, 32'd1, 16'h0, 0, 0, "R4");
        drive(4'd0, 32'd5, 32'd0, 16'hffff, 1, 0, "R5");
        drive(4'd5, 32'h0000_0001, 32'd0, 16'h8000, 1, 0, "R5");
        drive(4'd4, 32'hffff_ffff, 32'd0, 16'hf0f0, 1, 0, "R5");
        drive(4'd14, 32'hffff_fff0, 32'd0, 16'hfff8, 1, 0, "R5");
        idle(2);
        drive(4'd7, 32'h0f0f_0000, 32'h0000_00ff, 16'h0, 0, 0, "R6");
        drive(4'd6, 32'haaaa_5555, 32'hffff_0000, 16'h0, 0, 0, "R6");
        drive(4'd8, 32'h0000_0123, 32'd0, 16'h0, 0, 5'd4, "R7");
        drive(4'd10, 32'h8000_0000, 32'd0, 16'h0, 0, 5'd31, "R7");
        drive(4'd9, 32'h8000_0000, 32'd0, 16'h0, 0, 5'd31, "R7");
        drive(4'd12, 32'hf000_0000, 32'hffff_ffe3, 16'h0, 0, 0, "R8");
        drive(4'd13, 32'h8000_0000, 32'h0000_0024, 16'h0, 0, 0, "R8");
        drive(4'd11, 32'h0000_0001, 32'h1234_567f, 16'h0, 0, 0, "R8");
        drive(4'd14, 32'hffff_ffff, 32'd1, 16'h0, 0, 0, "R9");
        drive(4'd15, 32'hffff_ffff, 32'd1, 16'h0, 0, 0, "R9");
        drive(4'd14, 32'h7fff_ffff, 32'h8000_0000, 16'h0, 0, 0, "R9");
        drive(4'd15, 32'h7fff_ffff, 32'h8000_0000, 16'h0, 0, 0, "R9");
        drive(4'd15, 32'd7, 32'd7, 16'h0, 0, 0, "R9");
        idle(1);
        for (int i = 0; i < 400; i++) begin
            logic [3:0] op;
            op = 4'($urandom);
            drive(op, $urandom, $urandom, 16'($urandom), 1'($urandom), 5'($urandom), tag_of(op));
            if (i % 37 == 0) idle(1);
        end
        idle(4);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule